// File: doc/BRIEF.md
# Two-Queue Replacement Controller

This block is a fully associative tag directory that decides which resident block to give up when a new one must come in. It keeps three ordered tag lists. The first is an insertion FIFO that holds blocks seen only once. The second is a main queue kept in recency order, which holds blocks that have shown reuse. The third is a ghost list that holds only the identifiers of blocks recently pushed out of the FIFO. Blocks seen a single time, such as a long scan, therefore pass through the FIFO without flushing the reused working set from the main queue.

The cache pipeline presents one tag per cycle with a valid strobe. One cycle later the controller reports hit or miss and which list recognised the tag. When a resident block has to go, it also reports the victim tag with a valid flag. The controller holds no data and does not talk to the backing store. The caller moves the data, using the victim tag to know which line to reuse. The resident capacity, the FIFO target count, the ghost depth and the tag width are all parameters.

Top module: `q2_repl_ctrl`

## Requirements
- R1: A tag found in none of the three lists gives miss=1 with hit_src=0 and is appended at the tail of the insertion FIFO.
- R2: A tag held in the insertion FIFO gives hit=1 with hit_src=1. It leaves the FIFO, is placed at the most-recent end of the main queue, and produces no victim.
- R3: A tag held in the main queue gives hit=1 with hit_src=2 and moves to the most-recent end of that queue. The other main-queue entries keep their relative order.
- R4: A tag held in the ghost list gives miss=1 with hit_src=3. The entry is removed from the ghost list and the tag is inserted at the most-recent end of the main queue.
- R5: On any miss while the FIFO and main queue together hold RES_CAP tags, victim_valid=1. If the FIFO holds more than IN_TARGET tags, victim_tag is the FIFO head. Otherwise victim_tag is the least recently used main-queue tag. A miss below capacity gives victim_valid=0.
- R6: A tag evicted from the FIFO head is appended as the newest ghost entry. If the ghost list is already full, its oldest identifier is discarded without any report.
- R7: A ghost entry never produces hit=1. A tag whose ghost entry was discarded is treated as brand new (hit_src=0).
- R8: The result of an access accepted at a rising edge is visible after the next rising edge, and lasts one cycle. In a cycle with no accepted access, hit, miss and victim_valid are 0. hit and miss are never both 1.
- R9: A synchronous reset empties all three lists and clears the outputs.
- R10: A tag is held in at most one of the three lists at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_tag | input | TAG_W | Block tag of the access |
| hit | output | 1 | Previous access was resident |
| miss | output | 1 | Previous access was not resident |
| hit_src | output | 2 | 0 new, 1 FIFO, 2 main queue, 3 ghost |
| victim_valid | output | 1 | A resident block was evicted |
| victim_tag | output | TAG_W | Tag of the evicted block |

## Verification
The checks inside the design assume that the lists stay within their depths. They also assume that no tag ever sits in two lists at once. Both follow only if the caller presents a tag that is already resident as a hit, and never asks for that tag to be inserted again. The stimulus respects this because every access goes through the normal port, and the design alone decides where a tag goes.

The tag sequences are chosen to reach each case in turn: FIFO promotion, main-queue reordering, ghost revival, both victim choices, and ghost overflow. A mid-run reset and a long mixed sequence follow. Each result is compared against a queue-based model written from the requirements.

// File: rtl/q2_pkg.sv
package q2_pkg;
    typedef enum logic [1:0] {
        SRC_NEW   = 2'd0,
        SRC_FIFO  = 2'd1,
        SRC_MAIN  = 2'd2,
        SRC_GHOST = 2'd3
    } src_e;
endpackage

// File: rtl/q2_penc.sv
// Lowest-index priority encoder.
module q2_penc #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/q2_ordq.sv
// Ordered tag list: index 0 is the oldest entry. Each cycle it can remove one
// entry at any index (later entries close the gap) and then append one tag.
module q2_ordq #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    output logic [IW-1:0]    look_idx,
    output logic [TAG_W-1:0] head_tag,
    output logic [CW-1:0]    count,
    input  logic             rm_en,
    input  logic [IW-1:0]    rm_idx,
    input  logic             push_en,
    input  logic [TAG_W-1:0] push_tag
);
    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] ent;
        logic [CW-1:0]               cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0]    cnt_rm;
    logic [DEPTH-1:0] match;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = (st_q.ent[i] == look_tag) && (CW'(i) < st_q.cnt);
        end
    end

    q2_penc #(.N(DEPTH), .IW(IW)) u_penc (
        .vec (match),
        .any (look_hit),
        .idx (look_idx)
    );

    assign head_tag = st_q.ent[0];
    assign count    = st_q.cnt;

    always_comb begin
        st_d   = st_q;
        cnt_rm = st_q.cnt - CW'(rm_en);
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (rm_en && (IW'(i) >= rm_idx)) st_d.ent[i] = st_q.ent[i+1];
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (push_en && (CW'(i) == cnt_rm)) st_d.ent[i] = push_tag;
        end
        st_d.cnt = cnt_rm + CW'(push_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.ent <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: an append into a full list always comes with a removal
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push_en && !rm_en) |-> (st_q.cnt < CW'(DEPTH)));
    // R6: a removal only targets a valid entry
    a_r6_rm_in_range: assert property (@(posedge clk) disable iff (rst)
        rm_en |-> (CW'(rm_idx) < st_q.cnt));
    // R10: the count never exceeds the depth
    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/q2_repl_ctrl.sv
module q2_repl_ctrl
    import q2_pkg::*;
#(
    parameter int TAG_W       = 16,
    parameter int RES_CAP     = 4,
    parameter int IN_TARGET   = 1,
    parameter int GHOST_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [TAG_W-1:0] acc_tag,
    output logic             hit,
    output logic             miss,
    output logic [1:0]       hit_src,
    output logic             victim_valid,
    output logic [TAG_W-1:0] victim_tag
);
    localparam int RIW = (RES_CAP > 1) ? $clog2(RES_CAP) : 1;
    localparam int RCW = $clog2(RES_CAP + 1);
    localparam int GIW = (GHOST_DEPTH > 1) ? $clog2(GHOST_DEPTH) : 1;
    localparam int GCW = $clog2(GHOST_DEPTH + 1);

    typedef struct packed {
        logic             hit;
        logic             miss;
        src_e             src;
        logic             vv;
        logic [TAG_W-1:0] vtag;
    } res_t;

    res_t res_d, res_q;

    logic             f_hit, m_hit, g_hit;
    logic [RIW-1:0]   f_idx, m_idx;
    logic [GIW-1:0]   g_idx;
    logic [TAG_W-1:0] f_head, m_head, g_head;
    logic [RCW-1:0]   f_cnt, m_cnt;
    logic [GCW-1:0]   g_cnt;
    logic             f_rm, m_rm, g_rm, f_push, m_push, g_push;
    logic [RIW-1:0]   f_rm_idx, m_rm_idx;
    logic [GIW-1:0]   g_rm_idx;
    logic             res_full, take_fifo, fifo_evict;

    q2_ordq #(.DEPTH(RES_CAP), .TAG_W(TAG_W)) u_fifo (
        .clk(clk), .rst(rst), .look_tag(acc_tag), .look_hit(f_hit),
        .look_idx(f_idx), .head_tag(f_head), .count(f_cnt),
        .rm_en(f_rm), .rm_idx(f_rm_idx), .push_en(f_push), .push_tag(acc_tag)
    );

    q2_ordq #(.DEPTH(RES_CAP), .TAG_W(TAG_W)) u_main (
        .clk(clk), .rst(rst), .look_tag(acc_tag), .look_hit(m_hit),
        .look_idx(m_idx), .head_tag(m_head), .count(m_cnt),
        .rm_en(m_rm), .rm_idx(m_rm_idx), .push_en(m_push), .push_tag(acc_tag)
    );

    q2_ordq #(.DEPTH(GHOST_DEPTH), .TAG_W(TAG_W)) u_ghost (
        .clk(clk), .rst(rst), .look_tag(acc_tag), .look_hit(g_hit),
        .look_idx(g_idx), .head_tag(g_head), .count(g_cnt),
        .rm_en(g_rm), .rm_idx(g_rm_idx), .push_en(g_push), .push_tag(f_head)
    );

    assign res_full  = ({1'b0, f_cnt} + {1'b0, m_cnt}) == (RCW+1)'(RES_CAP);
    assign take_fifo = int'(f_cnt) > IN_TARGET;

    always_comb begin
        res_d      = '0;
        f_rm       = 1'b0;
        m_rm       = 1'b0;
        g_rm       = 1'b0;
        f_push     = 1'b0;
        m_push     = 1'b0;
        g_push     = 1'b0;
        f_rm_idx   = '0;
        m_rm_idx   = '0;
        g_rm_idx   = '0;
        fifo_evict = 1'b0;
        if (acc_valid) begin
            if (m_hit) begin
                res_d.hit = 1'b1;
                res_d.src = SRC_MAIN;
                m_rm      = 1'b1;
                m_rm_idx  = m_idx;
                m_push    = 1'b1;
            end else if (f_hit) begin
                res_d.hit = 1'b1;
                res_d.src = SRC_FIFO;
                f_rm      = 1'b1;
                f_rm_idx  = f_idx;
                m_push    = 1'b1;
            end else begin
                res_d.miss = 1'b1;
                if (g_hit) begin
                    res_d.src = SRC_GHOST;
                    g_rm      = 1'b1;
                    g_rm_idx  = g_idx;
                    m_push    = 1'b1;
                end else begin
                    res_d.src = SRC_NEW;
                    f_push    = 1'b1;
                end
                if (res_full) begin
                    res_d.vv = 1'b1;
                    if (take_fifo) begin
                        fifo_evict = 1'b1;
                        res_d.vtag = f_head;
                        f_rm       = 1'b1;
                        f_rm_idx   = '0;
                        g_push     = 1'b1;
                        if (!g_hit && (g_cnt == GCW'(GHOST_DEPTH))) begin
                            g_rm     = 1'b1;
                            g_rm_idx = '0;
                        end
                    end else begin
                        res_d.vtag = m_head;
                        m_rm       = 1'b1;
                        m_rm_idx   = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit          = res_q.hit;
    assign miss         = res_q.miss;
    assign hit_src      = res_q.src;
    assign victim_valid = res_q.vv;
    assign victim_tag   = res_q.vtag;

    // R10: a tag is never found in two lists at once
    a_r10_unique: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> $onehot0({f_hit, m_hit, g_hit}));
    // R5: the resident lists never hold more than the capacity
    a_r5_capacity: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, f_cnt} + {1'b0, m_cnt}) <= (RCW+1)'(RES_CAP));
    // R8: hit and miss are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss));
    // R8: no access, no result on the following cycle
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!hit && !miss && !victim_valid));
    // R5: a victim only accompanies a miss
    a_r5_victim_on_miss: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> miss);
    // R2: a FIFO hit grows the main queue by one
    a_r2_promote: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && f_hit && !m_hit) |=> (m_cnt == $past(m_cnt) + RCW'(1)));
    // R6: pushing into a full ghost list retires its oldest identifier
    a_r6_drop_oldest: assert property (@(posedge clk) disable iff (rst)
        (fifo_evict && !g_hit && (g_cnt == GCW'(GHOST_DEPTH)) && GHOST_DEPTH > 1)
        |=> (g_head != $past(g_head)));
endmodule

// File: tb/q2_repl_ctrl_tb.sv
module q2_repl_ctrl_tb;
    localparam int TAG_W = 16;
    localparam int CAP   = 4;
    localparam int TGT   = 1;
    localparam int GD    = 4;

    typedef struct packed {
        logic             hit;
        logic             miss;
        logic [1:0]       src;
        logic             vv;
        logic [TAG_W-1:0] vtag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 1'b0;
    logic [TAG_W-1:0] acc_tag = '0;
    logic             hit, miss, victim_valid;
    logic [1:0]       hit_src;
    logic [TAG_W-1:0] victim_tag;

    int n_checks = 0;
    int n_fail   = 0;

    logic [TAG_W-1:0] fq[$];
    logic [TAG_W-1:0] mq[$];
    logic [TAG_W-1:0] gq[$];
    exp_t             exp_q[$];
    string            lbl_q[$];

    always #5 clk = ~clk;

    q2_repl_ctrl #(.TAG_W(TAG_W), .RES_CAP(CAP), .IN_TARGET(TGT), .GHOST_DEPTH(GD)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_tag(acc_tag),
        .hit(hit), .miss(miss), .hit_src(hit_src),
        .victim_valid(victim_valid), .victim_tag(victim_tag)
    );

    task automatic model(input logic [TAG_W-1:0] t, output exp_t e);
        int mi = -1;
        int fi = -1;
        int gi = -1;
        logic [TAG_W-1:0] vt;
        logic fifo_vict = 1'b0;
        e = '0;
        foreach (mq[k]) if (mq[k] == t) mi = k;
        foreach (fq[k]) if (fq[k] == t) fi = k;
        foreach (gq[k]) if (gq[k] == t) gi = k;
        if (mi >= 0) begin
            e.hit = 1'b1; e.src = 2'd2;
            mq.delete(mi); mq.push_back(t);
        end else if (fi >= 0) begin
            e.hit = 1'b1; e.src = 2'd1;
            fq.delete(fi); mq.push_back(t);
        end else begin
            e.miss = 1'b1;
            if (fq.size() + mq.size() == CAP) begin
                e.vv = 1'b1;
                if (fq.size() > TGT) begin
                    vt = fq.pop_front();
                    fifo_vict = 1'b1;
                end else begin
                    vt = mq.pop_front();
                end
                e.vtag = vt;
            end
            if (gi >= 0) begin
                e.src = 2'd3;
                gq.delete(gi);
                mq.push_back(t);
            end else begin
                e.src = 2'd0;
                fq.push_back(t);
            end
            if (fifo_vict) begin
                if (gq.size() == GD) void'(gq.pop_front());
                gq.push_back(vt);
            end
        end
    endtask

    task automatic check(input string lbl, input logic ok, input exp_t act, input exp_t ex);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b miss=%0b src=%0d vv=%0b vtag=%h, expected hit=%0b miss=%0b src=%0d vv=%0b vtag=%h",
                     lbl, act.hit, act.miss, act.src, act.vv, act.vtag,
                     ex.hit, ex.miss, ex.src, ex.vv, ex.vtag);
        end
    endtask

    function automatic exp_t observed();
        exp_t o;
        o.hit = hit; o.miss = miss; o.src = hit_src;
        o.vv = victim_valid; o.vtag = victim_tag;
        return o;
    endfunction

    function automatic logic same(input exp_t a, input exp_t b);
        return a.hit == b.hit && a.miss == b.miss && a.src == b.src &&
               a.vv == b.vv && (!b.vv || a.vtag == b.vtag);
    endfunction

    // driver
    task automatic access(input logic [TAG_W-1:0] t, input string lbl);
        exp_t e;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_tag   = t;
        model(t, e);
        exp_q.push_back(e);
        lbl_q.push_back(lbl);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            acc_valid = 1'b0;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && (hit || miss || victim_valid)) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected result", 1'b0, observed(), '0);
                end else begin
                    exp_t e;
                    string l;
                    e = exp_q.pop_front();
                    l = lbl_q.pop_front();
                    check(l, same(observed(), e), observed(), e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 1'b0, observed(), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset state", !hit && !miss && !victim_valid, observed(), '0);

        access(16'h00A1, "R1 first A");
        access(16'h00B2, "R1 first B");
        access(16'h00C3, "R1 first C");
        access(16'h00D4, "R1 first D");
        access(16'h00B2, "R2 fifo hit B");
        access(16'h00B2, "R3 main hit B");
        access(16'h00E5, "R5 fifo victim A");
        access(16'h00A1, "R4 ghost revive A");
        access(16'h00D4, "R2 fifo hit D");
        access(16'h00F6, "R5 main LRU victim B");
        access(16'h00A1, "R3 main reorder A");
        access(16'h0007, "R6 ghost push E");
        access(16'h0008, "R6 ghost push");
        access(16'h0009, "R6 ghost push");
        access(16'h000A, "R6 ghost full drop oldest");
        access(16'h00C3, "R7 dropped tag is new");
        access(16'h00D4, "R3 main hit D");
        idle(1);
        @(negedge clk);
        check("R8 idle outputs low", !hit && !miss && !victim_valid, observed(), '0);

        // mid-run reset
        rst = 1'b1;
        fq.delete(); mq.delete(); gq.delete();
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check("R9 outputs cleared", !hit && !miss && !victim_valid, observed(), '0);
        access(16'h00D4, "R9 resident tag forgotten");
        access(16'h00D4, "R9 R2 refilled");

        // long mixed sequence
        for (int k = 0; k < 300; k++) begin
            access(TAG_W'((k * 7 + (k / 5) * 3) % 13), "R10 mixed");
            if (k % 17 == 0) idle(1);
        end
        idle(3);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule